// File: doc/BRIEF.md
# NAND bus strobe sequencer

This block connects an internal byte-request port to an 8-bit asynchronous parallel NAND device. Each accepted request moves one byte: a command byte with the command latch enable raised, an address byte with the address latch enable raised, a plain data byte written, or a data byte read. The device pins follow a fixed four-phase pattern, each phase lasting a number of clock cycles taken from a timing word: setup, strobe, hold and a turnaround gap before the next request may enter. Read and write accesses each have their own setup, strobe and hold counts.

All timing comes from one 32-bit configuration word written through a simple write port. The block takes a copy of the fields an access needs when it accepts the request, so a new word never changes an access that is already running. The device ready/busy line passes through a synchronizer and shows up in bit 0 of a status word.

Top module: `nand_strobe_seq`

## Requirements
- R1: For a write (request kinds 0, 1, 2), a programmed field value N gives a phase of N+1 cycles: setup from the write-setup field, strobe (write enable low) from the write-strobe field, hold from the write-hold field.
- R2: For a read (request kind 3), setup, strobe (read enable low) and hold take N+1 cycles from the read-setup, read-strobe and read-hold fields, and the write fields have no effect.
- R3: After the hold phase a turnaround gap of T+1 cycles follows, T being the turnaround field; req_ready is low from the cycle after acceptance until the gap ends, which is setup+strobe+hold+turnaround cycles in all.
- R4: Request kind encoding is 0 data write, 1 command write, 2 address write, 3 data read. The command latch enable is high for kind 1 and the address latch enable for kind 2, each for the whole of setup, strobe and hold. Neither is high for kinds 0 and 3, they are never high together, and both are low while idle.
- R5: With the strobe-select bit clear, chip-select is low from the first setup cycle to the last hold cycle. Write enable is low only during the strobe of a write and read enable only during the strobe of a read. The data bus drives the request byte (output enable high) from setup through hold of a write and never during a read.
- R6: With the strobe-select bit set, chip-select is low only during the strobe phase.
- R7: A read samples the data bus at the clock edge that ends the last strobe cycle; rsp_valid is high for exactly one cycle, the first hold cycle, with that byte on rsp_rdata.
- R8: The timing fields are copied when a request is accepted; a configuration write during an access changes only later accesses.
- R9: stat_word bit 0 follows nand_rb (1 = device ready) two clock edges later; all other status bits read 0.
- R10: The extended-wait bit has no effect: with it set and the device busy, an access completes with the same phase lengths.
- R11: During reset chip-select, write enable and read enable are high, both latch enables and the output enable are low, req_ready is high and rsp_valid is low.
- R12: Configuration word layout: bit 31 strobe select, bit 30 extended wait, [29:26] write setup, [25:20] write strobe, [19:17] write hold, [16:13] read setup, [12:7] read strobe, [6:4] read hold, [3:2] turnaround, [1:0] bus size (0 = 8-bit; the bus is always driven 8 bits wide).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 data write, 1 command, 2 address, 3 data read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read byte valid, one cycle |
| rsp_rdata | output | 8 | Read byte |
| stat_word | output | 32 | Status, bit 0 = device ready |
| nand_ce_n | output | 1 | Chip-select, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
Each request kind is tried under the worked example timing word, so command, address and plain data writes differ only in their latch enables, and a read shows that its own fields and not the write fields set its phases. A second word with unequal fields catches swapped or misplaced fields, and an all-zero word checks the shortest single-cycle phases. During a read the bench changes the data bus value just before and after the last strobe cycle, so sampling one cycle early or late gives a different byte. Separate runs set the strobe-select and extended-wait bits and rewrite the configuration mid-access to show the copy taken at acceptance.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   localparam int CFG_W   = 32;
   localparam int WSU_W   = 4;
   localparam int WST_W   = 6;
   localparam int WHD_W   = 3;
   localparam int RSU_W   = 4;
   localparam int RST_W   = 6;
   localparam int RHD_W   = 3;
   localparam int TA_W    = 2;
   localparam int BUS_W   = 2;
   localparam int CNT_W   = 6;

   typedef enum logic [1:0] {
      K_DATA_WR = 2'd0,
      K_CMD_WR  = 2'd1,
      K_ADDR_WR = 2'd2,
      K_DATA_RD = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_TURN   = 3'd4
   } phase_e;

   // Field order follows the bit positions software writes (MSB first).
   typedef struct packed {
      logic             sel_mode;
      logic             ext_wait;
      logic [WSU_W-1:0] wr_setup;
      logic [WST_W-1:0] wr_strobe;
      logic [WHD_W-1:0] wr_hold;
      logic [RSU_W-1:0] rd_setup;
      logic [RST_W-1:0] rd_strobe;
      logic [RHD_W-1:0] rd_hold;
      logic [TA_W-1:0]  turn;
      logic [BUS_W-1:0] bus_size;
   } nand_cfg_t;

endpackage

// File: rtl/nseq_cfg_reg.sv
module nseq_cfg_reg
   import nseq_pkg::*;
#(
   parameter logic [CFG_W-1:0] CFG_RESET = 32'h3FFF_FFFC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output nand_cfg_t        cfg
);

   generate
      if ($bits(nand_cfg_t) != CFG_W) begin : g_bad_layout
         $error("configuration struct must fill the whole word");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= nand_cfg_t'(CFG_RESET);
      else if (cfg_we) cfg <= nand_cfg_t'(cfg_wdata);
   end

endmodule

// File: rtl/nseq_rdy_sync.sv
module nseq_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_async,
   output logic rb_sync
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("STAGES must be between 0 and 4");
      end
      if (STAGES == 0) begin : g_pass
         assign rb_sync = rb_async;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= rb_async;
               for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign rb_sync = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nseq_phase_fsm.sv
module nseq_phase_fsm
   import nseq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      start_rd,
   input  nand_cfg_t cfg,
   output phase_e    phase,
   output logic      last,
   output logic      sel_mode
);

   generate
      if (CNT_W < WST_W || CNT_W < RST_W || CNT_W < WSU_W || CNT_W < RSU_W)
      begin : g_bad_cnt
         $error("phase counter narrower than a timing field");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] snap_strobe;
   logic [CNT_W-1:0] snap_hold;
   logic [CNT_W-1:0] snap_turn;
   logic             snap_sel;

   assign last     = (cnt == '0);
   assign sel_mode = snap_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         cnt         <= '0;
         snap_strobe <= '0;
         snap_hold   <= '0;
         snap_turn   <= '0;
         snap_sel    <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase     <= PH_SETUP;
                  snap_turn <= CNT_W'(cfg.turn);
                  snap_sel  <= cfg.sel_mode;
                  if (start_rd) begin
                     cnt         <= CNT_W'(cfg.rd_setup);
                     snap_strobe <= CNT_W'(cfg.rd_strobe);
                     snap_hold   <= CNT_W'(cfg.rd_hold);
                  end else begin
                     cnt         <= CNT_W'(cfg.wr_setup);
                     snap_strobe <= CNT_W'(cfg.wr_strobe);
                     snap_hold   <= CNT_W'(cfg.wr_hold);
                  end
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= snap_strobe;
               end else cnt <= cnt - 1'b1;
            end
            PH_STROBE: begin
               if (last) begin
                  phase <= PH_HOLD;
                  cnt   <= snap_hold;
               end else cnt <= cnt - 1'b1;
            end
            PH_HOLD: begin
               if (last) begin
                  phase <= PH_TURN;
                  cnt   <= snap_turn;
               end else cnt <= cnt - 1'b1;
            end
            PH_TURN: begin
               if (last) phase <= PH_IDLE;
               else      cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R1
   phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !last) |=> phase == $past(phase));

   // R8
   snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> ($stable(snap_strobe) && $stable(snap_hold)
                              && $stable(snap_turn) && $stable(snap_sel)));

   // R3
   turn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TURN) |=> (phase == PH_TURN || phase == PH_IDLE));

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nseq_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CFG_W-1:0] CFG_RESET   = 32'h3FFF_FFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [CFG_W-1:0]  stat_word,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DATA_W-1:0] nand_dq_o,
   output logic              nand_dq_oe,
   input  logic [DATA_W-1:0] nand_dq_i,
   input  logic              nand_rb
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("only an 8-bit device bus is supported");
      end
   endgenerate

   nand_cfg_t         cfg;
   phase_e            phase;
   logic              last;
   logic              sel_mode;
   logic              rb_s;
   logic              accept;
   req_kind_e         kind_q;
   logic [DATA_W-1:0] wdata_q;
   logic              in_access;
   logic              is_rd;
   logic              cfg_unused;

   assign cfg_unused = ^{cfg.ext_wait, cfg.bus_size};

   nseq_cfg_reg #(.CFG_RESET(CFG_RESET)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg       (cfg)
   );

   nseq_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rb_async (nand_rb),
      .rb_sync  (rb_s)
   );

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   nseq_phase_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .start_rd (req_kind_e'(req_kind) == K_DATA_RD),
      .cfg      (cfg),
      .phase    (phase),
      .last     (last),
      .sel_mode (sel_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= K_DATA_WR;
         wdata_q <= '0;
      end else if (accept) begin
         kind_q  <= req_kind_e'(req_kind);
         wdata_q <= req_wdata;
      end
   end

   assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign is_rd     = (kind_q == K_DATA_RD);

   assign nand_ce_n  = sel_mode ? !(phase == PH_STROBE) : !in_access;
   assign nand_cle   = in_access && (kind_q == K_CMD_WR);
   assign nand_ale   = in_access && (kind_q == K_ADDR_WR);
   assign nand_we_n  = !((phase == PH_STROBE) && !is_rd);
   assign nand_re_n  = !((phase == PH_STROBE) && is_rd);
   assign nand_dq_oe = in_access && !is_rd;
   assign nand_dq_o  = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else if (phase == PH_STROBE && last && is_rd) begin
         rsp_valid <= 1'b1;
         rsp_rdata <= nand_dq_i;
      end else begin
         rsp_valid <= 1'b0;
      end
   end

   assign stat_word = {{(CFG_W-1){1'b0}}, rb_s};

   // R4
   le_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R4
   le_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!nand_cle && !nand_ale));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R5
   we_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

   // R3
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_ce_n |-> !req_ready);

   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7
   rsp_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> ($past(!nand_re_n) && nand_re_n));

endmodule

// File: tb/tb_nand_strobe_seq.sv
module tb_nand_strobe_seq;

   localparam logic [1:0] K_DATA = 2'd0;
   localparam logic [1:0] K_CMD  = 2'd1;
   localparam logic [1:0] K_ADDR = 2'd2;
   localparam logic [1:0] K_RD   = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [31:0] stat_word;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_o;
   logic [7:0]  nand_dq_i = '0;
   logic        nand_rb = 1'b1;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   nand_strobe_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .stat_word(stat_word), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
      .nand_rb(nand_rb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Word built from the R12 layout.
   function automatic logic [31:0] mk_cfg(input bit sel, input bit ew, input int ws,
      input int wst, input int wh, input int rs, input int rst, input int rh, input int ta);
      logic [3:0] a; logic [5:0] b; logic [2:0] c;
      logic [3:0] d; logic [5:0] e; logic [2:0] f; logic [1:0] g;
      a = 4'(ws); b = 6'(wst); c = 3'(wh); d = 4'(rs); e = 6'(rst); f = 3'(rh); g = 2'(ta);
      return {sel, ew, a, b, c, d, e, f, g, 2'b00};
   endfunction

   task automatic write_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_access(input logic [1:0] kind, input logic [7:0] wd,
      input int es, input int est, input int eh, input int et, input bit sel,
      input logic [7:0] ybyte, input bit do_mid, input logic [31:0] mid_word,
      input string rq);
      int  c_su = 0, c_st = 0, c_hd = 0, c_ta = 0, cyc = 0;
      int  le_bad = 0, ce_bad = 0, oe_bad = 0, stb_bad = 0;
      int  rsp_cnt = 0, rsp_hd = -1;
      logic [7:0] rsp_dat = '0;
      bit  seen = 0;
      @(negedge clk);
      chk(req_ready == 1'b1, {rq, " ready before request"}, req_ready, 1);
      req_valid = 1'b1; req_kind = kind; req_wdata = wd;
      @(posedge clk);
      #1 req_valid = 1'b0; req_wdata = 8'h00;
      for (int g = 0; g < 400; g++) begin
         bit strb, wrong, act;
         @(negedge clk);
         if (do_mid && cyc == 0) begin cfg_we = 1'b1; cfg_wdata = mid_word; end
         if (do_mid && cyc == 1) cfg_we = 1'b0;
         if (req_ready) break;
         cyc++;
         strb  = (kind == K_RD) ? !nand_re_n : !nand_we_n;
         wrong = (kind == K_RD) ? !nand_we_n : !nand_re_n;
         act   = sel ? (nand_cle || nand_ale || nand_dq_oe) : !nand_ce_n;
         if (wrong) stb_bad++;
         if (strb) begin
            c_st++; seen = 1;
            if (kind == K_RD) nand_dq_i = (c_st == est) ? ybyte : 8'hA5;
         end else if (act) begin
            if (!seen) c_su++; else c_hd++;
            if (kind == K_RD && seen) nand_dq_i = 8'h3C;
         end else if (seen) c_ta++;
         if (nand_cle != ((act || strb) && kind == K_CMD)) le_bad++;
         if (nand_ale != ((act || strb) && kind == K_ADDR)) le_bad++;
         if (nand_cle && nand_ale) le_bad++;
         if (sel && !nand_ce_n && !strb) ce_bad++;
         if (!sel && strb && nand_ce_n) ce_bad++;
         if (kind == K_RD && nand_dq_oe) oe_bad++;
         if (kind != K_RD && (act || strb) && (!nand_dq_oe || nand_dq_o != wd)) oe_bad++;
         if (rsp_valid) begin rsp_cnt++; rsp_dat = rsp_rdata; rsp_hd = c_hd; end
      end
      chk(c_su == es, {rq, " setup cycles"}, c_su, es);
      chk(c_st == est, {rq, " strobe cycles"}, c_st, est);
      chk(c_hd == eh, {rq, " hold cycles"}, c_hd, eh);
      chk(c_ta == et, {"R3 turnaround cycles (", rq, ")"}, c_ta, et);
      chk(cyc == es + est + eh + et, "R3 ready low cycles", cyc, es + est + eh + et);
      chk(le_bad == 0, "R4 latch enable selection", le_bad, 0);
      chk(ce_bad == 0, sel ? "R6 chip-select window" : "R5 chip-select window", ce_bad, 0);
      chk(oe_bad == 0, "R5 data bus drive", oe_bad, 0);
      chk(stb_bad == 0, "R5 wrong strobe", stb_bad, 0);
      if (kind == K_RD) begin
         chk(rsp_cnt == 1, "R7 response pulses", rsp_cnt, 1);
         chk(rsp_dat == ybyte, "R7 captured byte", rsp_dat, ybyte);
         chk(rsp_hd == 1, "R7 response in first hold cycle", rsp_hd, 1);
      end else begin
         chk(rsp_cnt == 0, "R7 no response on write", rsp_cnt, 0);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(nand_ce_n && nand_we_n && nand_re_n, "R11 strobes high in reset",
          {nand_ce_n, nand_we_n, nand_re_n}, 7);
      chk(!nand_cle && !nand_ale && !nand_dq_oe, "R11 enables low in reset",
          {nand_cle, nand_ale, nand_dq_oe}, 0);
      chk(req_ready && !rsp_valid, "R11 handshake in reset", {req_ready, rsp_valid}, 2);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_example();
      logic [31:0] w;
      w = mk_cfg(0, 0, 1, 3, 1, 1, 5, 1, 3);
      chk(w == 32'h0432_229C, "R12 example word", int'(w), int'(32'h0432_229C));
      write_cfg(w);
      run_access(K_CMD,  8'h70, 2, 4, 2, 4, 0, 8'h00, 0, '0, "R1 cmd");
      run_access(K_ADDR, 8'h12, 2, 4, 2, 4, 0, 8'h00, 0, '0, "R1 addr");
      run_access(K_DATA, 8'hC3, 2, 4, 2, 4, 0, 8'h00, 0, '0, "R1 data");
      run_access(K_RD,   8'h00, 2, 6, 2, 4, 0, 8'h5A, 0, '0, "R2 read");
   endtask

   task automatic t_uneven();
      write_cfg(mk_cfg(0, 0, 7, 10, 3, 2, 12, 5, 1));
      run_access(K_DATA, 8'h96, 8, 11, 4, 2, 0, 8'h00, 0, '0, "R1 uneven write");
      run_access(K_RD,   8'h00, 3, 13, 6, 2, 0, 8'hE7, 0, '0, "R2 uneven read");
   endtask

   task automatic t_zero();
      write_cfg(32'h0000_0000);
      run_access(K_CMD, 8'hFF, 1, 1, 1, 1, 0, 8'h00, 0, '0, "R1 zero write");
      run_access(K_RD,  8'h00, 1, 1, 1, 1, 0, 8'h81, 0, '0, "R2 zero read");
   endtask

   task automatic t_select();
      write_cfg(mk_cfg(1, 0, 1, 3, 1, 1, 5, 1, 3));
      run_access(K_CMD, 8'h90, 2, 4, 2, 4, 1, 8'h00, 0, '0, "R6 select cmd");
   endtask

   task automatic t_snapshot();
      write_cfg(mk_cfg(0, 0, 1, 3, 1, 1, 5, 1, 3));
      run_access(K_DATA, 8'h44, 2, 4, 2, 4, 0, 8'h00, 1,
                 mk_cfg(0, 0, 4, 2, 0, 1, 5, 1, 2), "R8 old fields");
      run_access(K_DATA, 8'h55, 5, 3, 1, 3, 0, 8'h00, 0, '0, "R8 new fields");
   endtask

   task automatic t_extwait();
      write_cfg(mk_cfg(0, 1, 1, 3, 1, 1, 5, 1, 3));
      nand_rb = 1'b0;
      repeat (3) @(negedge clk);
      run_access(K_ADDR, 8'h21, 2, 4, 2, 4, 0, 8'h00, 0, '0, "R10 ext wait busy");
      nand_rb = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_status();
      @(negedge clk);
      chk(stat_word == 32'h1, "R9 ready reported", int'(stat_word), 1);
      nand_rb = 1'b0;
      @(negedge clk);
      chk(stat_word == 32'h1, "R9 one edge later", int'(stat_word), 1);
      @(negedge clk);
      chk(stat_word == 32'h0, "R9 busy after two edges", int'(stat_word), 0);
      nand_rb = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(stat_word == 32'h1, "R9 ready again", int'(stat_word), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_example();
      t_uneven();
      t_zero();
      t_select();
      t_snapshot();
      t_extwait();
      t_status();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule